// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a byte-oriented two-wire slave that gives a host read and write access to a bank of 8-bit registers held outside the block. The clock and data lines are sampled by the system clock through a synchronizer. The block pulls the data line low through a single open-drain enable output. An index pointer selects the target register. The host writes this pointer as the first byte after the address. It then writes one data byte, or it issues a repeated START and reads one byte back.

The three low bits of the 7-bit slave address come from strap inputs. The block captures them while reset is held and keeps them fixed until the next reset. Two identification bytes are answered inside the block. Indices below the external window boundary are forwarded to the register port. That port has a one-cycle write strobe and a one-cycle read strobe, so that registers which clear when read can react.

Top module: `twi_regport_slave`

## Requirements
- R1: While and right after reset, `sda_oe`, `reg_we` and `reg_re` are 0.
- R2: The slave address is the 7-bit value 0011 followed by `strap_a[2:0]` (strap_a[2] most significant). The straps are captured on every clock edge with `rst` high, and later strap changes have no effect until the next reset.
- R3: An address byte whose upper seven bits do not match is not acknowledged. The slave then leaves SDA released and ignores the bus until the next START.
- R4: A write transaction is START, address with bit0=0, index byte, data byte and STOP. The slave acknowledges every byte of it. `reg_we` pulses for exactly one cycle with `reg_idx` equal to the index and `reg_wdata` equal to the data.
- R5: A read transaction is START, address with W, index byte, repeated START, address with bit0=1 and 8 data bits. The slave acknowledges all three bytes. `reg_re` pulses for one cycle with `reg_idx` equal to the index, and the slave shifts `reg_rdata` out MSB first.
- R6: Reading index 0x20 returns 0x60, and reading index 0x21 returns the parameter ID_LO (default 0x5A). Neither read raises `reg_re`.
- R7: Reading any index of 0x22 or above returns 0x00 without `reg_re`. Writes to indices of 0x20 or above are acknowledged but raise no `reg_we`.
- R8: A STOP seen anywhere returns the slave to idle, and a START seen anywhere restarts the address phase. A write cut off before its data byte completes raises no `reg_we`.
- R9: `sda_oe` changes only while the synchronized clock line is low, except when a START or STOP aborts a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_a | input | 3 | Low address bits, sampled during reset |
| reg_idx | output | 8 | Current register index pointer |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | One-cycle write strobe to the register file |
| reg_rdata | input | 8 | Read data from the register file for reg_idx |
| reg_re | output | 1 | One-cycle read strobe when a byte is loaded for shifting |

## Verification
The host model drives the bus with several patterns. Full writes and reads at several indices separate correct bit order and index handling from shifted or swapped bytes. Reads of the two identification indices and of an index above them check the internal answer path against the forwarded path. A wrong address byte, a STOP right after the index and a repeated START in the middle of a write separate correct abort handling from stray strobes. Re-strapping under a second reset, followed by pin changes after it, shows whether the address is latched or follows the pins live.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_MACK
    } link_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    function automatic logic addr_hit(input logic [6:0] rx_addr,
                                      input logic [6:0] own_addr);
        return rx_addr == own_addr;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t ev
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_prev;
    logic          sda_prev;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[LAST-1:0], scl_in};
                    sda_pipe <= {sda_pipe[LAST-1:0], sda_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[LAST];
        ev.sda      = sda_pipe[LAST];
        ev.scl_rise = scl_pipe[LAST] & ~scl_prev;
        ev.scl_fall = ~scl_pipe[LAST] & scl_prev;
        ev.start    = scl_pipe[LAST] & scl_prev & sda_prev & ~sda_pipe[LAST];
        ev.stop     = scl_pipe[LAST] & scl_prev & ~sda_prev & sda_pipe[LAST];
    end

endmodule

// File: rtl/twi_strap_latch.sv
module twi_strap_latch #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] strap_in,
    output logic [WIDTH-1:0] strap_q
);
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_in;
    end
endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
    import twi_pkg::*;
#(
    parameter logic [6:0] OWN_MASK_HI = 7'b0011000,
    parameter int         STRAP_W     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  line_evt_t          ev,
    input  logic [STRAP_W-1:0] strap_q,
    input  logic [BYTE_W-1:0]  tx_byte,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  ptr,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               wr_pulse,
    output logic               rd_pulse
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    link_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              ack_drv;
    logic              rnw;
    logic [6:0]        own_addr;
    logic              rx_state;

    assign own_addr = OWN_MASK_HI | 7'(strap_q);
    assign rx_state = (state == ST_ADDR) || (state == ST_INDEX) || (state == ST_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sr      <= '0;
            tx_sr   <= '0;
            ptr     <= '0;
            ack_drv <= 1'b0;
            rnw     <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            ack_drv <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            ack_drv <= 1'b0;
        end else begin
            if (rx_state && ev.scl_rise && cnt != FULL) begin
                sr  <= {sr[BYTE_W-2:0], ev.sda};
                cnt <= cnt + 1'b1;
            end
            unique case (state)
                ST_ADDR: if (ev.scl_fall && cnt == FULL) begin
                    if (addr_hit(sr[7:1], own_addr)) begin
                        ack_drv <= 1'b1;
                        rnw     <= sr[0];
                        state   <= ST_ADDR_ACK;
                    end else begin
                        state   <= ST_IDLE;
                    end
                end
                ST_INDEX: if (ev.scl_fall && cnt == FULL) begin
                    ptr     <= sr;
                    ack_drv <= 1'b1;
                    state   <= ST_INDEX_ACK;
                end
                ST_WDATA: if (ev.scl_fall && cnt == FULL) begin
                    ack_drv <= 1'b1;
                    state   <= ST_WDATA_ACK;
                end
                ST_ADDR_ACK: if (ev.scl_fall) begin
                    ack_drv <= 1'b0;
                    cnt     <= '0;
                    if (rnw) begin
                        tx_sr <= tx_byte;
                        state <= ST_TX;
                    end else begin
                        state <= ST_INDEX;
                    end
                end
                ST_INDEX_ACK: if (ev.scl_fall) begin
                    ack_drv <= 1'b0;
                    cnt     <= '0;
                    state   <= ST_WDATA;
                end
                ST_WDATA_ACK: if (ev.scl_fall) begin
                    ack_drv <= 1'b0;
                    state   <= ST_IDLE;
                end
                ST_TX: if (ev.scl_fall) begin
                    if (cnt == LAST) begin
                        state <= ST_MACK;
                    end else begin
                        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                ST_MACK: if (ev.scl_rise) state <= ST_IDLE;
                default: ;
            endcase
        end
    end

    assign sda_oe   = ack_drv | ((state == ST_TX) & ~tx_sr[BYTE_W-1]);
    assign rx_byte  = sr;
    assign wr_pulse = (state == ST_WDATA) && ev.scl_fall && (cnt == FULL);
    assign rd_pulse = (state == ST_ADDR_ACK) && ev.scl_fall && rnw;

endmodule

// File: rtl/twi_regport_slave.sv
module twi_regport_slave
    import twi_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         STRAP_W     = 3,
    parameter logic [6:0] ADDR_HI     = 7'b0011000,
    parameter logic [7:0] EXT_LIMIT   = 8'h20,
    parameter logic [7:0] ID_HI       = 8'h60,
    parameter logic [7:0] ID_LO       = 8'h5A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_a,
    output logic [7:0]         reg_idx,
    output logic [7:0]         reg_wdata,
    output logic               reg_we,
    input  logic [7:0]         reg_rdata,
    output logic               reg_re
);
    localparam logic [7:0] ID_HI_IDX = EXT_LIMIT;
    localparam logic [7:0] ID_LO_IDX = EXT_LIMIT + 8'd1;

    line_evt_t          ev;
    logic [STRAP_W-1:0] addr_lo;
    logic [7:0]         ptr;
    logic [7:0]         rx_byte;
    logic [7:0]         tx_byte;
    logic               wr_pulse;
    logic               rd_pulse;
    logic               in_ext;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    twi_strap_latch #(.WIDTH(STRAP_W)) u_strap (
        .clk      (clk),
        .rst      (rst),
        .strap_in (strap_a),
        .strap_q  (addr_lo)
    );

    twi_link_fsm #(.OWN_MASK_HI(ADDR_HI), .STRAP_W(STRAP_W)) u_link (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .strap_q  (addr_lo),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .ptr      (ptr),
        .rx_byte  (rx_byte),
        .wr_pulse (wr_pulse),
        .rd_pulse (rd_pulse)
    );

    assign in_ext = ptr < EXT_LIMIT;

    always_comb begin
        if (in_ext)                tx_byte = reg_rdata;
        else if (ptr == ID_HI_IDX) tx_byte = ID_HI;
        else if (ptr == ID_LO_IDX) tx_byte = ID_LO;
        else                       tx_byte = 8'h00;
    end

    assign reg_idx   = ptr;
    assign reg_wdata = rx_byte;
    assign reg_we    = wr_pulse & in_ext;
    assign reg_re    = rd_pulse & in_ext;

endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk #(
    parameter int         STRAP_W   = 3,
    parameter logic [7:0] EXT_LIMIT = 8'h20
) (
    input logic               clk,
    input logic               rst,
    input logic               sda_oe,
    input logic               reg_we,
    input logic               reg_re,
    input logic [7:0]         reg_idx,
    input logic               scl_s,
    input logic               line_evt,
    input logic [STRAP_W-1:0] addr_lo
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sda_oe && !reg_we && !reg_re));

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(addr_lo));

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R5
    re_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    // R7
    we_window_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_re) |-> (reg_idx < EXT_LIMIT));

    // R9
    oe_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (($rose(sda_oe) || $fell(sda_oe)) && !$past(line_evt)) |-> !scl_s);
endmodule

bind twi_regport_slave twi_slave_chk #(.STRAP_W(STRAP_W), .EXT_LIMIT(EXT_LIMIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_idx  (reg_idx),
    .scl_s    (ev.scl),
    .line_evt (ev.start | ev.stop),
    .addr_lo  (addr_lo)
);

// File: tb/test_twi_regport_slave.sv
`timescale 1ns/1ps
module test_twi_regport_slave;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [2:0] strap_a = 3'b101;
    logic [7:0] reg_idx, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic       sda_bus;

    logic [7:0] regs [0:31];
    logic [15:0] exp_wq[$];
    logic [7:0]  exp_rq[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_idx[4:0]];

    twi_regport_slave i_twi_regport_slave (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .strap_a(strap_a), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .reg_re(reg_re)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference register file and per-clock comparison of strobes
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_wq.size() == 0) check(0, "R4/R7/R8 unexpected write", {reg_idx, reg_wdata}, 0);
            else begin
                logic [15:0] e;
                e = exp_wq.pop_front();
                check({reg_idx, reg_wdata} == e, "R4 write strobe", {reg_idx, reg_wdata}, e);
            end
            regs[reg_idx[4:0]] = reg_wdata;
        end
        if (!rst && reg_re) begin
            if (exp_rq.size() == 0) check(0, "R6/R7 unexpected read strobe", reg_idx, 0);
            else begin
                logic [7:0] e;
                e = exp_rq.pop_front();
                check(reg_idx == e, "R5 read strobe index", reg_idx, e);
            end
        end
    end

    task automatic waitq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1);
        sda_m = 1'b0; waitq(1); scl_m = 1'b0; waitq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(1); scl_m = 1'b1; waitq(1);
        sda_m = 1'b1; waitq(1);
    endtask

    task automatic byte_out(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq(1); scl_m = 1'b1; waitq(2); scl_m = 1'b0; waitq(1);
        end
        sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1);
        ack = ~sda_bus;
        waitq(1); scl_m = 1'b0; waitq(1);
    endtask

    task automatic byte_in(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            waitq(1); scl_m = 1'b1; waitq(1); b[i] = sda_bus; waitq(1); scl_m = 1'b0; waitq(1);
        end
        sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(2); scl_m = 1'b0; waitq(1);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d,
                            input string tag);
        bit k0, k1, k2;
        bus_start();
        byte_out({a, 1'b0}, k0);
        byte_out(idx, k1);
        byte_out(d, k2);
        bus_stop();
        check(k0 && k1 && k2, tag, {k0, k1, k2}, 3'b111);
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] idx, output logic [7:0] d,
                           input string tag);
        bit k0, k1, k2;
        bus_start();
        byte_out({a, 1'b0}, k0);
        byte_out(idx, k1);
        bus_start();
        byte_out({a, 1'b1}, k2);
        byte_in(d);
        bus_stop();
        check(k0 && k1 && k2, tag, {k0, k1, k2}, 3'b111);
    endtask

    task automatic do_reset(input logic [2:0] s);
        rst = 1'b1; strap_a = s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        bit k;
        for (int i = 0; i < 32; i++) regs[i] = 8'(8'hA0 ^ (i * 7));
        regs[10] = 8'h81;

        do_reset(3'b101);
        // R1 reset state
        check(sda_oe == 0, "R1 sda_oe idle", sda_oe, 0);
        check(reg_we == 0, "R1 reg_we idle", reg_we, 0);
        check(reg_re == 0, "R1 reg_re idle", reg_re, 0);

        // R4 write 0xC3 to index 5 at address 0x1D
        exp_wq.push_back({8'h05, 8'hC3});
        do_write(7'h1D, 8'h05, 8'hC3, "R4 acks on write");
        check(regs[5] == 8'hC3, "R4 register updated", regs[5], 8'hC3);

        // R5 reads, MSB first
        exp_rq.push_back(8'h05);
        do_read(7'h1D, 8'h05, rd, "R5 acks on read");
        check(rd == 8'hC3, "R5 read data idx5", rd, 8'hC3);
        exp_rq.push_back(8'h0A);
        do_read(7'h1D, 8'h0A, rd, "R5 acks on read");
        check(rd == 8'h81, "R5 read data idx10", rd, 8'h81);

        // R6 identification bytes
        do_read(7'h1D, 8'h20, rd, "R6 acks");
        check(rd == 8'h60, "R6 id high", rd, 8'h60);
        do_read(7'h1D, 8'h21, rd, "R6 acks");
        check(rd == 8'h5A, "R6 id low", rd, 8'h5A);

        // R7 reserved read and ignored write
        do_read(7'h1D, 8'h40, rd, "R7 acks");
        check(rd == 8'h00, "R7 reserved reads zero", rd, 0);
        do_write(7'h1D, 8'h22, 8'h55, "R7 write acked");
        check(exp_wq.size() == 0, "R7 no write strobe", exp_wq.size(), 0);

        // R3 wrong address
        bus_start();
        byte_out({7'h1C, 1'b0}, k);
        check(!k, "R3 wrong address not acked", k, 0);
        byte_out(8'h03, k);
        check(!k, "R3 silent after mismatch", k, 0);
        bus_stop();

        // R8 STOP after index aborts write
        bus_start();
        byte_out({7'h1D, 1'b0}, k);
        byte_out(8'h07, k);
        bus_stop();
        check(regs[7] == 8'(8'hA0 ^ 49), "R8 aborted write ignored", regs[7], 8'(8'hA0 ^ 49));

        // R8 repeated START mid-write restarts address phase
        exp_wq.push_back({8'h09, 8'h11});
        bus_start();
        byte_out({7'h1D, 1'b0}, k);
        byte_out(8'h08, k);
        bus_start();
        byte_out({7'h1D, 1'b0}, k);
        check(k, "R8 address acked after restart", k, 1);
        byte_out(8'h09, k);
        byte_out(8'h11, k);
        bus_stop();
        check(regs[9] == 8'h11 && regs[8] == 8'(8'hA0 ^ 56), "R8 restart write target",
              regs[9], 8'h11);

        // R2 new straps latched at reset, later pin changes ignored
        do_reset(3'b010);
        strap_a = 3'b101;
        bus_start();
        byte_out({7'h1D, 1'b0}, k);
        bus_stop();
        check(!k, "R2 old address rejected", k, 0);
        exp_wq.push_back({8'h03, 8'h7E});
        do_write(7'h1A, 8'h03, 8'h7E, "R2 latched address acked");
        check(regs[3] == 8'h7E, "R2 write via latched address", regs[3], 8'h7E);

        waitq(2);
        check(exp_wq.size() == 0, "R4 all writes seen", exp_wq.size(), 0);
        check(exp_rq.size() == 0, "R5 all reads seen", exp_rq.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule